// File: doc/BRIEF.md
# Calendar Alarm Comparator with Latched and Pulsed Interrupt

This block watches a set of calendar fields: second, minute, hour, date, month, year and day of week. It compares them against a bank of alarm registers. Each alarm register carries a compare value in its low bits and an enable flag in its top bit. The comparison is taken once per second, on a strobe from the timekeeping logic. When every enabled field agrees with the current time, the block raises an alarm status flag and pulls an active-low interrupt line.

A mode input selects one of two behaviours. In latched (single-event) mode the interrupt line stays low until the host clears the status flag. In pulsed mode each match produces a low pulse of a fixed number of clock cycles, and the alarm re-arms by itself. The interrupt pin is shared with a frequency-output function. While that function is selected, or while the alarm master enable is off, the alarm takes no action and the line is released at once.

Top module: `cal_alarm`

## Requirements
- R1: A match is recognised only in a cycle where `sec_tick` is 1; without the strobe the status flag does not change.
- R2: Field slot i occupies `now_fields[i*7 +: 7]` and `alarm_regs[i*8 +: 8]`, with slot 0 second, 1 minute, 2 hour, 3 date, 4 month, 5 year and 6 day of week. Bit 7 of each alarm byte enables that slot, and bits 6:0 are the compare value. A disabled slot is ignored, and if no slot is enabled no match occurs.
- R3: A recognised match sets `alm_flag` on the following clock edge.
- R4: With `pulse_mode`=0, `irq_n` is low whenever `alm_flag` is 1 and the alarm is gated on. A cycle with `alm_clr`=1 clears the flag at the next edge, which returns `irq_n` high. If a match and a clear occur in the same cycle, the match wins.
- R5: With `pulse_mode`=1, a match drives `irq_n` low for exactly PULSE_CYCLES cycles after the edge that sets the flag and then releases it. A later match gives a new pulse even though the flag is still set.
- R6: While `alarm_on`=0 or `fout_en`=1, no match is recognised and `irq_n` is high in the same cycle. The flag keeps its value, and `irq_n` again follows the flag once the gate reopens.
- R7: After reset `alm_flag` is 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle once-per-second strobe |
| now_fields | input | NUM_FIELDS*FIELD_W | Current calendar fields, slot 0 in the low bits |
| alarm_regs | input | NUM_FIELDS*(FIELD_W+1) | Alarm bytes: enable in the top bit, compare value below |
| alarm_on | input | 1 | Alarm master enable |
| pulse_mode | input | 1 | 0 selects latched mode, 1 selects pulsed mode |
| fout_en | input | 1 | Shared pin assigned to frequency output |
| alm_clr | input | 1 | Host write of 0 to the status flag |
| alm_flag | output | 1 | Alarm status flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The embedded properties check these rules on every cycle:
- The flag only rises after a strobe.
- A qualified match always sets the flag.
- A clear without a match empties the flag.
- The pulse counter never exceeds its length.
- The line is high whenever the gate is closed.

Only the bench scenarios can show which field patterns count as a match: disabled slots, an all-disabled bank and a mismatching enabled slot. The same holds for the exact pulse width in cycles, for re-arming during a held flag, and for the immediate release and resumption of the line as `fout_en` toggles.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
   typedef enum logic {
      MODE_LATCHED = 1'b0,
      MODE_PULSED  = 1'b1
   } alarm_mode_e;

   localparam int SLOT_SEC   = 0;
   localparam int SLOT_MIN   = 1;
   localparam int SLOT_HOUR  = 2;
   localparam int SLOT_DATE  = 3;
   localparam int SLOT_MONTH = 4;
   localparam int SLOT_YEAR  = 5;
   localparam int SLOT_DOW   = 6;
endpackage

// File: rtl/alarm_field_match.sv
module alarm_field_match #(
   parameter int NUM_FIELDS = 7,
   parameter int FIELD_W    = 7
) (
   input  logic [NUM_FIELDS*FIELD_W-1:0]     now_fields,
   input  logic [NUM_FIELDS*(FIELD_W+1)-1:0] alarm_regs,
   output logic                              hit
);
   localparam int REG_W = FIELD_W + 1;

   logic [NUM_FIELDS-1:0] slot_en;
   logic [NUM_FIELDS-1:0] slot_ok;

   generate
      if (NUM_FIELDS < 1) begin : g_bad_count
         $error("alarm_field_match: NUM_FIELDS must be at least 1");
      end
      if (FIELD_W < 1) begin : g_bad_width
         $error("alarm_field_match: FIELD_W must be at least 1");
      end
      for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_slot
         assign slot_en[i] = alarm_regs[i*REG_W + FIELD_W];
         assign slot_ok[i] = ~slot_en[i] |
            (alarm_regs[i*REG_W +: FIELD_W] == now_fields[i*FIELD_W +: FIELD_W]);
      end
   endgenerate

   assign hit = (|slot_en) & (&slot_ok);
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
   import cal_alarm_pkg::*;
#(
   parameter int PULSE_CYCLES = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        set_evt,
   input  logic        clr,
   input  alarm_mode_e mode,
   input  logic        gate,
   output logic        alm_flag,
   output logic        irq_active
);
   localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);

   generate
      if (PULSE_CYCLES < 1) begin : g_bad_pulse
         $error("alarm_irq_ctrl: PULSE_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] pulse_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alm_flag <= 1'b0;
      end else if (set_evt) begin
         alm_flag <= 1'b1;
      end else if (clr) begin
         alm_flag <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_cnt <= '0;
      end else if (!gate) begin
         pulse_cnt <= '0;
      end else if (set_evt && mode == MODE_PULSED) begin
         pulse_cnt <= CNT_LOAD;
      end else if (pulse_cnt != '0) begin
         pulse_cnt <= pulse_cnt - 1'b1;
      end
   end

   always_comb begin
      if (!gate)
         irq_active = 1'b0;
      else if (mode == MODE_PULSED)
         irq_active = (pulse_cnt != '0);
      else
         irq_active = alm_flag;
   end

   p_set_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> alm_flag);

   p_clear_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set_evt) |=> !alm_flag);

   p_pulse_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_cnt <= CNT_LOAD);

   p_latched_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_flag && !clr) |=> alm_flag);
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
   import cal_alarm_pkg::*;
#(
   parameter int NUM_FIELDS   = 7,
   parameter int FIELD_W      = 7,
   parameter int PULSE_CYCLES = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              sec_tick,
   input  logic [NUM_FIELDS*FIELD_W-1:0]     now_fields,
   input  logic [NUM_FIELDS*(FIELD_W+1)-1:0] alarm_regs,
   input  logic                              alarm_on,
   input  logic                              pulse_mode,
   input  logic                              fout_en,
   input  logic                              alm_clr,
   output logic                              alm_flag,
   output logic                              irq_n
);
   logic        hit;
   logic        gate;
   logic        set_evt;
   logic        irq_active;
   alarm_mode_e mode;

   assign mode    = alarm_mode_e'(pulse_mode);
   assign gate    = alarm_on & ~fout_en;
   assign set_evt = sec_tick & gate & hit;
   assign irq_n   = ~irq_active;

   alarm_field_match #(
      .NUM_FIELDS (NUM_FIELDS),
      .FIELD_W    (FIELD_W)
   ) u_match (
      .now_fields (now_fields),
      .alarm_regs (alarm_regs),
      .hit        (hit)
   );

   alarm_irq_ctrl #(
      .PULSE_CYCLES (PULSE_CYCLES)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_evt    (set_evt),
      .clr        (alm_clr),
      .mode       (mode),
      .gate       (gate),
      .alm_flag   (alm_flag),
      .irq_active (irq_active)
   );

   p_rise_needs_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alm_flag) |-> $past(sec_tick));

   p_gate_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_on || fout_en) |-> irq_n);

   p_reset_idle_r7: assert property (@(posedge clk)
      !rst_n |-> (!alm_flag && irq_n));
endmodule

// File: tb/cal_alarm_test.sv
`timescale 1ns/1ps
module cal_alarm_test;
   localparam int NF = 7;
   localparam int FW = 7;
   localparam int RW = FW + 1;
   localparam int PC = 4;

   typedef struct {
      logic  flag;
      logic  irq;
      string tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sec_tick = 1'b0;
   logic [NF*FW-1:0]  now_fields = '0;
   logic [NF*RW-1:0]  alarm_regs = '0;
   logic              alarm_on = 1'b0;
   logic              pulse_mode = 1'b0;
   logic              fout_en = 1'b0;
   logic              alm_clr = 1'b0;
   logic              alm_flag;
   logic              irq_n;

   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 1'b0;
   exp_t exp_q[$];

   always #2 clk = ~clk;

   cal_alarm #(.NUM_FIELDS(NF), .FIELD_W(FW), .PULSE_CYCLES(PC)) uut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .now_fields(now_fields),
      .alarm_regs(alarm_regs), .alarm_on(alarm_on), .pulse_mode(pulse_mode),
      .fout_en(fout_en), .alm_clr(alm_clr), .alm_flag(alm_flag), .irq_n(irq_n));

   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_checks++;
         if (alm_flag !== e.flag || irq_n !== e.irq) begin
            n_fail++;
            $display("FAIL %s: flag/irq_n got %b/%b expected %b/%b",
                     e.tag, alm_flag, irq_n, e.flag, e.irq);
         end
      end
   end

   task automatic step(input logic f, input logic q, input string tag);
      exp_t e;
      @(posedge clk);
      e.flag = f; e.irq = q; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      #1;
      sec_tick = 1'b0;
      alm_clr  = 1'b0;
   endtask

   task automatic check_now(input logic f, input logic q, input string tag);
      #1;
      n_checks++;
      if (alm_flag !== f || irq_n !== q) begin
         n_fail++;
         $display("FAIL %s: flag/irq_n got %b/%b expected %b/%b",
                  tag, alm_flag, irq_n, f, q);
      end
   endtask

   task automatic set_now(input int idx, input logic [FW-1:0] v);
      now_fields[idx*FW +: FW] = v;
   endtask

   task automatic set_alm(input int idx, input logic en, input logic [FW-1:0] v);
      alarm_regs[idx*RW +: RW] = {en, v};
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: run did not complete, got hung expected done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NF; i++) set_now(i, FW'(i + 10));
      repeat (3) @(negedge clk);
      check_now(1'b0, 1'b1, "R7 reset state");
      rst_n = 1'b1;
      @(negedge clk); #1;
      alarm_on = 1'b1;

      // R2: values equal but no slot enabled
      for (int i = 0; i < NF; i++) set_alm(i, 1'b0, FW'(i + 10));
      sec_tick = 1'b1;
      step(1'b0, 1'b1, "R2 no slot enabled");

      // R1: enabled match without strobe
      set_alm(0, 1'b1, FW'(10));
      step(1'b0, 1'b1, "R1 no strobe no match");
      step(1'b0, 1'b1, "R1 no strobe no match");

      // R3/R4: strobe with match, latched mode
      sec_tick = 1'b1;
      step(1'b1, 1'b0, "R3 match sets flag");
      for (int k = 0; k < 3; k++) step(1'b1, 1'b0, "R4 latched hold");
      alm_clr = 1'b1;
      step(1'b0, 1'b1, "R4 clear releases");

      // R2: enabled mismatch
      set_alm(1, 1'b1, FW'(99));
      sec_tick = 1'b1;
      step(1'b0, 1'b1, "R2 enabled mismatch");
      // R2: disabled slot differing is ignored (minute off, hour value differs)
      set_alm(1, 1'b0, FW'(99));
      set_alm(2, 1'b0, FW'(77));
      set_alm(6, 1'b1, FW'(16));
      sec_tick = 1'b1;
      step(1'b1, 1'b0, "R2 disabled slot ignored");
      alm_clr = 1'b1;
      step(1'b0, 1'b1, "R4 clear");

      // R6: gate closed blocks match
      fout_en = 1'b1; sec_tick = 1'b1;
      step(1'b0, 1'b1, "R6 fout blocks match");
      fout_en = 1'b0; alarm_on = 1'b0; sec_tick = 1'b1;
      step(1'b0, 1'b1, "R6 alarm off blocks match");
      alarm_on = 1'b1;

      // R6: immediate release and resumption
      sec_tick = 1'b1;
      step(1'b1, 1'b0, "R3 match sets flag");
      fout_en = 1'b1;
      check_now(1'b1, 1'b1, "R6 immediate release");
      step(1'b1, 1'b1, "R6 stays released");
      fout_en = 1'b0;
      check_now(1'b1, 1'b0, "R6 resumes on reopen");

      // R4: match wins over clear
      alm_clr = 1'b1; sec_tick = 1'b1;
      step(1'b1, 1'b0, "R4 match wins over clear");
      alm_clr = 1'b1;
      step(1'b0, 1'b1, "R4 clear");

      // R5: pulsed mode
      pulse_mode = 1'b1;
      sec_tick = 1'b1;
      for (int k = 0; k < PC; k++) step(1'b1, 1'b0, "R5 pulse low");
      step(1'b1, 1'b1, "R5 pulse ends");
      step(1'b1, 1'b1, "R5 stays high");
      sec_tick = 1'b1;
      for (int k = 0; k < PC; k++) step(1'b1, 1'b0, "R5 rearm pulse");
      step(1'b1, 1'b1, "R5 rearm pulse ends");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule